// File: doc/BRIEF.md
# Ping-Pong DMA Channel

This block is one DMA channel that runs from two hardware buffer descriptors, slot A and slot B. Each slot holds a current address and an end word. Software loads a slot, enables the channel, and the channel issues one transfer request per beat on a request/acknowledge handshake. On every acknowledged beat the active slot's address moves forward by the beat size. When the address reaches the slot's end, the channel moves to the other slot, so the stream continues without a gap while software refills the slot that has just emptied.

An interrupt line stays high while the channel is enabled and a slot is empty. A status byte tells software which slot to reload. It also reports an overflow, which means the active buffer ran out before the other slot was refilled; the channel stalls until a reload arrives. Two flag bits in an end word mark the final buffer. After that buffer completes, the channel turns itself off and pulses a done output.

Top module: `dbuf_dma_chan`

## Requirements
- R1: Register offsets on `reg_addr` are: 0 slot A address, 1 slot A end word, 2 slot B address, 3 slot B end word, 4 control, 5 status. Reads are combinational. An end word reads back as written. In an end word, bit 31 is the stop flag, bit 30 is the last flag, and bits 29:0 are the end address.
- R2: Control bits are: [1:0] beat size as log2 of bytes, bit 5 device-to-memory, bit 6 clear, bit 7 enable. Clear is not stored and reads as 0. `xfer_size` and `xfer_to_mem` follow the stored fields. After reset, control reads 0 and status reads 0x01.
- R3: While a request is held without an acknowledge, `xfer_addr` stays stable. Each acknowledged beat advances the active slot's address by 2^size. Beats are issued in the order the buffers were loaded.
- R4: A buffer completes on the beat whose advanced address equals the end address. The flag bits take no part in that compare. If the other slot is loaded, the channel requests from it in the very next cycle.
- R5: Status bits are: bit 7 interrupt pending, bit 6 overflow, bit 0 slot select. Software reloads slot B when overflow and slot select are equal, and slot A when they differ.
- R6: `irq` is high exactly while the channel is enabled and at least one slot is empty. Writing a slot's end word marks that slot loaded.
- R7: Overflow is set when the active buffer completes while the other slot is empty. While overflow is set, no request is issued. An end-word write clears overflow, and transfers resume from the reloaded slot.
- R8: When a buffer whose end word has both flag bits set completes, the enable bit clears, `done` is high for one cycle in the following cycle, and no further request is issued.
- R9: A control write with the clear bit set empties both slots and clears overflow. The next slot to reload and to walk becomes A.
- R10: Writing 0 to control drops `xfer_req` from the next cycle. The active address keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| xfer_req | output | 1 | Beat request |
| xfer_ack | input | 1 | Beat acknowledge; the beat completes on a cycle with request and acknowledge both high |
| xfer_addr | output | 30 | Address of the requested beat |
| xfer_to_mem | output | 1 | 1 = device to memory |
| xfer_size | output | 2 | Beat size, log2 of bytes |
| irq | output | 1 | A slot needs reloading |
| done | output | 1 | One-cycle pulse after the final buffer |

## Verification
The assertions assume the following about software and the transfer partner:
- Software writes a slot only while that slot is empty.
- Software loads slots in the order it reads from the status byte.
- Each buffer spans a non-zero whole number of beats.
- `xfer_ack` is raised only while a request is pending.
- A control write never coincides with an acknowledge.

The bench keeps to these rules. It generates buffer lengths as whole multiples of the beat size, drops the acknowledge while it drives any register write, and picks the reload slot from its own model. The status decode is compared against that model rather than used to steer the stimulus. The random acknowledge gaps and the random service delays create overflows naturally, and directed sequences then cover the stall, the gapless switch, disabling mid-buffer and the beat sizes.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;

   typedef enum logic [2:0] {
      OFS_CUR_A = 3'd0,
      OFS_END_A = 3'd1,
      OFS_CUR_B = 3'd2,
      OFS_END_B = 3'd3,
      OFS_CTRL  = 3'd4,
      OFS_STAT  = 3'd5
   } reg_ofs_e;

   localparam int CTL_EN    = 7;
   localparam int CTL_CLR   = 6;
   localparam int CTL_TOMEM = 5;

   localparam int ST_PEND = 7;
   localparam int ST_OVF  = 6;
   localparam int ST_SEL  = 0;

   localparam logic SLOT_A = 1'b0;
   localparam logic SLOT_B = 1'b1;

endpackage

// File: rtl/dbdma_slot.sv
module dbdma_slot #(
   parameter int DATA_W = 32,
   parameter int SIZE_W = 2,
   localparam int ADDR_W = DATA_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              ld_cur,
   input  logic              ld_end,
   input  logic [DATA_W-1:0] wdata,
   input  logic              step,
   input  logic [SIZE_W-1:0] beat_sz,
   output logic [ADDR_W-1:0] cur,
   output logic [DATA_W-1:0] endw,
   output logic              loaded,
   output logic              fin,
   output logic              final_buf
);

   logic [ADDR_W-1:0] inc;
   logic [ADDR_W-1:0] nxt;

   assign inc       = ADDR_W'(1) << beat_sz;
   assign nxt       = cur + inc;
   assign fin       = step && (nxt == endw[ADDR_W-1:0]);
   assign final_buf = endw[DATA_W-1] & endw[DATA_W-2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur    <= '0;
         endw   <= '0;
         loaded <= 1'b0;
      end else begin
         if (ld_cur)
            cur <= wdata[ADDR_W-1:0];
         else if (step)
            cur <= nxt;
         if (ld_end)
            endw <= wdata;
         if (flush)
            loaded <= 1'b0;
         else if (ld_end)
            loaded <= 1'b1;
         else if (fin)
            loaded <= 1'b0;
      end
   end

   // R4: a finished buffer leaves its slot empty
   assert_retire_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && !ld_end) |=> !loaded);

endmodule

// File: rtl/dbdma_seq.sv
module dbdma_seq #(
   parameter int SIZE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              ctl_en,
   input  logic              ctl_clr,
   input  logic              ctl_tomem,
   input  logic [SIZE_W-1:0] ctl_size,
   input  logic [1:0]        end_wr,
   input  logic [1:0]        loaded,
   input  logic [1:0]        fin,
   input  logic [1:0]        final_buf,
   output logic              en,
   output logic              to_mem,
   output logic [SIZE_W-1:0] size,
   output logic              up,
   output logic              fp,
   output logic              ovf,
   output logic              done,
   output logic              flush
);
   import dbdma_pkg::*;

   logic fin_up;
   logic last_up;
   logic other;

   assign flush   = ctl_wr && ctl_clr;
   assign fin_up  = fin[up];
   assign last_up = final_buf[up];
   assign other   = ~up;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= 1'b0;
         to_mem <= 1'b0;
         size   <= '0;
         up     <= SLOT_A;
         fp     <= SLOT_A;
         ovf    <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (fin_up) begin
            up <= other;
            if (last_up) begin
               en   <= 1'b0;
               done <= 1'b1;
            end else if (!loaded[other] && !end_wr[other]) begin
               ovf <= 1'b1;
            end
         end
         if (|end_wr) begin
            ovf <= 1'b0;
            fp  <= end_wr[0] ? SLOT_B : SLOT_A;
         end
         if (ctl_wr) begin
            en     <= ctl_en;
            to_mem <= ctl_tomem;
            size   <= ctl_size;
            if (ctl_clr) begin
               up  <= SLOT_A;
               fp  <= SLOT_A;
               ovf <= 1'b0;
            end
         end
      end
   end

   // R7: overflow only rises after a buffer completion
   assert_ovf_after_fin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $past(fin[0] | fin[1]));

   // R8: the done pulse coincides with a stopped channel
   assert_done_disables_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !$past(ctl_wr)) |-> !en);

endmodule

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan #(
   parameter int DATA_W = 32,
   parameter int SIZE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              xfer_req,
   input  logic              xfer_ack,
   output logic [DATA_W-3:0] xfer_addr,
   output logic              xfer_to_mem,
   output logic [SIZE_W-1:0] xfer_size,
   output logic              irq,
   output logic              done
);
   import dbdma_pkg::*;

   localparam int ADDR_W = DATA_W - 2;
   localparam int NSLOT  = 2;

   if (DATA_W < 12 || DATA_W > 64) begin : g_bad_data_w
      $error("dbuf_dma_chan: DATA_W must lie in 12..64");
   end
   if (SIZE_W < 1 || SIZE_W > 3) begin : g_bad_size_w
      $error("dbuf_dma_chan: SIZE_W must lie in 1..3");
   end
   if ((2 ** SIZE_W) > ADDR_W) begin : g_bad_span
      $error("dbuf_dma_chan: largest beat exceeds address width");
   end

   reg_ofs_e          ofs;
   logic              en, to_mem, up, fp, ovf, flush, ctl_wr;
   logic [SIZE_W-1:0] size;
   logic [NSLOT-1:0]  loaded, fin, final_buf, end_wr;
   logic [ADDR_W-1:0] cur   [NSLOT];
   logic [DATA_W-1:0] endw  [NSLOT];
   logic [ADDR_W-1:0] beat_inc;
   logic [7:0]        stat_b, ctl_b;

   assign ofs    = reg_ofs_e'(reg_addr);
   assign ctl_wr = reg_wr && (ofs == OFS_CTRL);

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic ld_cur_s;
      logic step_s;
      assign ld_cur_s  = reg_wr && (reg_addr == 3'(2 * s));
      assign end_wr[s] = reg_wr && (reg_addr == 3'(2 * s + 1));
      assign step_s    = xfer_req && xfer_ack && (up == 1'(s));
      dbdma_slot #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .flush     (flush),
         .ld_cur    (ld_cur_s),
         .ld_end    (end_wr[s]),
         .wdata     (reg_wdata),
         .step      (step_s),
         .beat_sz   (size),
         .cur       (cur[s]),
         .endw      (endw[s]),
         .loaded    (loaded[s]),
         .fin       (fin[s]),
         .final_buf (final_buf[s])
      );
   end

   dbdma_seq #(.SIZE_W(SIZE_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .ctl_en    (reg_wdata[CTL_EN]),
      .ctl_clr   (reg_wdata[CTL_CLR]),
      .ctl_tomem (reg_wdata[CTL_TOMEM]),
      .ctl_size  (reg_wdata[SIZE_W-1:0]),
      .end_wr    (end_wr),
      .loaded    (loaded),
      .fin       (fin),
      .final_buf (final_buf),
      .en        (en),
      .to_mem    (to_mem),
      .size      (size),
      .up        (up),
      .fp        (fp),
      .ovf       (ovf),
      .done      (done),
      .flush     (flush)
   );

   assign xfer_req    = en && loaded[up] && !ovf;
   assign xfer_addr   = cur[up];
   assign xfer_to_mem = to_mem;
   assign xfer_size   = size;
   assign irq         = en && !(&loaded);
   assign beat_inc    = ADDR_W'(1) << size;

   always_comb begin
      stat_b          = '0;
      stat_b[ST_PEND] = irq;
      stat_b[ST_OVF]  = ovf;
      stat_b[ST_SEL]  = ovf ? fp : ~fp;
      ctl_b                = '0;
      ctl_b[CTL_EN]        = en;
      ctl_b[CTL_TOMEM]     = to_mem;
      ctl_b[SIZE_W-1:0]    = size;
      case (ofs)
         OFS_CUR_A: reg_rdata = DATA_W'(cur[0]);
         OFS_END_A: reg_rdata = endw[0];
         OFS_CUR_B: reg_rdata = DATA_W'(cur[1]);
         OFS_END_B: reg_rdata = endw[1];
         OFS_CTRL:  reg_rdata = DATA_W'(ctl_b);
         OFS_STAT:  reg_rdata = DATA_W'(stat_b);
         default:   reg_rdata = '0;
      endcase
   end

   // R3: a pending request holds its address until acknowledged
   assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_ack && !reg_wr) |=> (xfer_req && $stable(xfer_addr)));

   // R3: a mid-buffer beat moves the address by one beat
   assert_beat_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && xfer_ack && !reg_wr && !(|fin)) |=>
         (xfer_addr == $past(xfer_addr + beat_inc)));

   // R4: completion with the other slot loaded continues without a gap
   assert_switch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((|fin) && !final_buf[up] && loaded[~up] && !reg_wr) |=> xfer_req);

   // R6: an enabled channel in overflow always signals
   assert_ovf_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && en) |-> irq);

   // R10: disabling through control stops requests at once
   assert_disable_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !reg_wdata[CTL_EN]) |=> !xfer_req);

endmodule

// File: tb/sim_dbuf_dma_chan.sv
module sim_dbuf_dma_chan;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        reg_wr = 0;
   logic [2:0]  reg_addr = 0;
   logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;
   logic        xfer_req;
   logic        xfer_ack = 0;
   logic [29:0] xfer_addr;
   logic        xfer_to_mem;
   logic [1:0]  xfer_size;
   logic        irq;
   logic        done;

   int checks = 0;
   int errors = 0;

   // bench-side model of the loaded buffers, in consumption order
   logic [29:0] bstart [64];
   logic [29:0] bend   [64];
   bit          bfin   [64];
   int          nbuf, cons;
   bit          have_exp, exp_done, done_seen;
   logic [29:0] e_addr;
   int          step;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dbuf_dma_chan u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_req(xfer_req),
      .xfer_ack(xfer_ack), .xfer_addr(xfer_addr), .xfer_to_mem(xfer_to_mem),
      .xfer_size(xfer_size), .irq(irq), .done(done)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d; xfer_ack = 0;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   function automatic logic slot_from_status(input logic [31:0] s);
      return ~(s[6] ^ s[0]); // R5: equal bits -> B (1), differing -> A (0)
   endfunction

   task automatic reset_model(input int sz);
      nbuf = 0; cons = 0; have_exp = 0; exp_done = 0; done_seen = 0; step = 1 << sz;
   endtask

   task automatic load(input logic slot, input logic [29:0] st, input int beats, input bit fl);
      logic [29:0] en_a;
      en_a = st + 30'(beats * step);
      wr({1'b0, slot, 1'b0}, {2'b00, st});
      wr({1'b0, slot, 1'b1}, {fl, fl, en_a});
      bstart[nbuf] = st; bend[nbuf] = en_a; bfin[nbuf] = fl;
      if (!have_exp) begin e_addr = st; have_exp = 1; end
      nbuf++;
   endtask

   task automatic tick(input int prob);
      logic a;
      a = xfer_req && (($urandom % 100) < prob);
      if (a) begin
         if (!have_exp) chk("R3 beat with no buffer", 1, 0);
         else begin
            chk("R3 beat address", {2'b00, xfer_addr}, {2'b00, e_addr});
            e_addr = e_addr + 30'(step);
            if (e_addr == bend[cons]) begin
               if (bfin[cons]) exp_done = 1;
               cons++;
               if (cons < nbuf) e_addr = bstart[cons];
               else have_exp = 0;
            end
         end
      end
      xfer_ack = a;
      @(negedge clk);
      xfer_ack = 0;
      if (exp_done) begin
         chk("R8 done pulse", {31'd0, done}, 1);
         exp_done = 0; done_seen = 1;
      end else if (done) chk("R8 unexpected done", 1, 0);
   endtask

   task automatic run_to_done(input int prob, input int limit);
      for (int i = 0; i < limit && !done_seen; i++) tick(prob);
      chk("R8 final buffer finished", {31'd0, done_seen}, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic        sel, fill;
      int          total, loaded_cnt;
      void'($urandom(32'd7741));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // reset state (R2)
      rd(3'd5, d); chk("R2 reset status", d, 32'h01);
      rd(3'd4, d); chk("R2 reset control", d, 32'h00);
      chk("R2 reset req/irq/done", {29'd0, xfer_req, irq, done}, 0);

      // register readback (R1, R2)
      wr(3'd2, 32'h0000_1234); rd(3'd2, d); chk("R1 slot B address", d, 32'h0000_1234);
      wr(3'd3, 32'hC000_2000); rd(3'd3, d); chk("R1 slot B end word", d, 32'hC000_2000);
      wr(3'd0, 32'h0000_0AB0); rd(3'd0, d); chk("R1 slot A address", d, 32'h0000_0AB0);
      wr(3'd4, 32'h0000_0063); rd(3'd4, d); chk("R2 control readback, clear not stored", d, 32'h23);
      chk("R2 size/dir pins", {29'd0, xfer_to_mem, xfer_size}, 32'h7);

      // clear with enable (R9, R5, R6)
      reset_model(2);
      wr(3'd4, 32'hC2);
      rd(3'd5, d); chk("R9 status after clear", d, 32'h81);
      chk("R9 no request with empty slots", {31'd0, xfer_req}, 0);
      chk("R6 irq with empty slots", {31'd0, irq}, 1);
      load(1'b0, 30'h1000, 8, 0);
      chk("R6 irq while slot B empty", {31'd0, irq}, 1);
      load(1'b1, 30'h2000, 2, 1);
      chk("R6 irq low with both loaded", {31'd0, irq}, 0);
      rd(3'd5, d); chk("R5 status both loaded", d, 32'h01);

      // disable mid-buffer (R10)
      for (int i = 0; i < 3; i++) tick(100);
      wr(3'd4, 32'h02);
      chk("R10 request dropped", {31'd0, xfer_req}, 0);
      rd(3'd0, d); chk("R10 address kept", d, 32'h100C);
      chk("R6 irq low when disabled", {31'd0, irq}, 0);
      for (int i = 0; i < 4; i++) begin
         tick(100); chk("R10 stays idle", {31'd0, xfer_req}, 0);
      end

      // gapless switch A -> B (R4)
      wr(3'd4, 32'h42);
      reset_model(2);
      load(1'b0, 30'h3000, 2, 0);
      load(1'b1, 30'h5000, 2, 1);
      wr(3'd4, 32'h82);
      for (int i = 0; i < 4; i++) begin
         chk("R4 request every cycle", {31'd0, xfer_req}, 1);
         tick(100);
      end
      chk("R8 done after gapless pair", {31'd0, done_seen}, 1);
      rd(3'd4, d); chk("R8 enable cleared", d & 32'h80, 32'h0);
      tick(100); chk("R8 no request after final", {31'd0, xfer_req}, 0);

      // overflow stall (R7, R5)
      wr(3'd4, 32'hC2);
      reset_model(2);
      load(1'b0, 30'h0800, 3, 0);
      for (int i = 0; i < 40 && have_exp; i++) tick(100);
      tick(100);
      chk("R7 no request in overflow", {31'd0, xfer_req}, 0);
      rd(3'd5, d); chk("R7 overflow status selects B", d, 32'hC1);
      for (int i = 0; i < 5; i++) begin
         tick(100); chk("R7 stall holds", {31'd0, xfer_req}, 0);
      end
      load(1'b1, 30'h0900, 2, 1);
      rd(3'd5, d); chk("R7 overflow cleared by reload", d, 32'h81);
      chk("R7 resumes from B", {2'b00, xfer_addr}, 32'h0900);
      run_to_done(100, 50);

      // beat sizes (R3, R2)
      wr(3'd4, 32'hE0);
      reset_model(0);
      chk("R2 to-mem and size 0", {29'd0, xfer_to_mem, xfer_size}, 32'h4);
      load(1'b0, 30'h0101, 3, 1);
      run_to_done(70, 100);
      wr(3'd4, 32'hC3);
      reset_model(3);
      load(1'b0, 30'h0200, 2, 1);
      run_to_done(70, 100);

      // random stream with random service delays (R3, R4, R5, R6, R7, R8)
      wr(3'd4, 32'hC2);
      reset_model(2);
      total = 14; loaded_cnt = 0; fill = 1'b0;
      for (int i = 0; i < 6000 && !done_seen; i++) begin
         if (irq && loaded_cnt < total && ($urandom % 4 == 0)) begin
            rd(3'd5, d);
            sel = slot_from_status(d);
            chk("R5 reload slot from status", {31'd0, sel}, {31'd0, fill});
            if (d[6]) chk("R7 stalled while overflow", {31'd0, xfer_req}, 0);
            load(fill, 30'({($urandom % 4096), 2'b00}), 1 + ($urandom % 6),
                 loaded_cnt == total - 1);
            loaded_cnt++;
            fill = ~fill;
         end else begin
            tick(60);
         end
      end
      chk("R8 stream finished", {31'd0, done_seen}, 1);
      chk("R3 all buffers consumed", cons, total);
      chk("R8 irq low after final", {31'd0, irq}, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule